// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the control register space of an audio codec as a host sees it. A simple 32-bit bus reaches it, with single-cycle access. The bus carries a byte address, a write strobe, write data and combinational read data. The window holds sixteen 32-bit direct slots, selected by the byte address divided by four. Slot 0 holds a pointer. Its low five bits pick one of thirty-two 8-bit indirect registers. Slot 1 is the data window that reads and writes the register picked by that pointer.

Some indirect entries have special rules. Entry 3 can be written but always reads back as zero. Entries 11 and 25 are read-only. Entry 12 keeps only one writable bit and always carries a fixed codec version code. Direct slot 2 is read-only. A write to direct slot 4 with bit 0 set restores the whole block to its power-up state, and slot 4 then keeps the 7-bit value that was just written. The interrupt output exists for wiring only and never asserts.

Top module: `codec_regfile`

## Requirements
- R1: Holding rst_n low for a clock edge clears every direct slot and every indirect entry to zero. The exceptions are indirect entry 12, which becomes 0x8A, and indirect entry 25, which becomes 0xA0.
- R2: Direct slots 0, 3 and 5 to 15 store the full 32-bit write data and return it unchanged on read.
- R3: The window index is bits [4:0] of direct slot 0. A read of slot 1 returns the selected indirect entry in bits [7:0], with bits [31:8] zero.
- R4: While the index is 3, a read of slot 1 returns zero, even after data has been written to entry 3.
- R5: A write to slot 1 updates only the selected indirect entry from bits [7:0] of the write data. Slot 0 and every other entry keep their values.
- R6: Writes through the window to entries 11 and 25 are ignored. Entry 25 keeps reading 0xA0.
- R7: A write through the window to entry 12 stores (data AND 0x40) OR 0x8A.
- R8: Writes to direct slot 2 are ignored, and the slot reads zero.
- R9: A write to slot 4 with bit 0 set gives the state of R1 at the next edge, except that slot 4 then holds the write data AND 0x7F.
- R10: A write to slot 4 with bit 0 clear stores the data AND 0x7F and changes no other register.
- R11: irq_out is low in every cycle.
- R12: Read data follows the current address from the current register state in the same cycle. A write is visible to reads from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates occur on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte address; bits [5:2] select the direct slot |
| bus_we | input | 1 | Write strobe for the addressed slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | 1 | Interrupt request, always low |

## Verification
The bench aims at the quirky window entries. A design that forgot the write-only rule would echo data at entry 3. One that missed the read-only rule would let 0xA0 at entry 25 be overwritten. A wrong mask at entry 12 would show bits other than 0x40 changing. The soft reset gets special care: a design that gave the reset priority over the slot-4 write would read slot 4 back as zero instead of the masked value, and one that forgot the indirect entries would leave stale window data behind. Long mixed streams of writes, including random soft resets, are compared against a behavioural model every cycle to catch wrong index decoding or writes leaking into the wrong slot.

// File: rtl/cdc_regs_pkg.sv
// Package: shared constants, register kinds and reset values for the
// indexed codec register file. Assumes slot and entry numbers are small
// non-negative integers.
package cdc_regs_pkg;

    // Direct slot roles
    localparam int INDEX_SLOT  = 0;
    localparam int WINDOW_SLOT = 1;
    localparam int LOCKED_SLOT = 2;
    localparam int CTRL_SLOT   = 4;

    // Indirect entry roles
    localparam int WO_ENTRY    = 3;
    localparam int RO_ENTRY    = 11;
    localparam int VER_ENTRY   = 12;
    localparam int CHIP_ENTRY  = 25;

    // Fixed values and masks
    localparam logic [7:0] CODEC_VER    = 8'h8A;
    localparam logic [7:0] CHIP_VER     = 8'hA0;
    localparam logic [7:0] VER_KEEP     = 8'h40;
    localparam int         CTRL_KEEP_W  = 7;

    typedef enum logic [1:0] {
        SK_PLAIN,
        SK_WINDOW,
        SK_LOCKED,
        SK_CTRL
    } slot_kind_e;

    typedef enum logic [1:0] {
        EK_PLAIN,
        EK_RO,
        EK_VER
    } entry_kind_e;

    // Role of a direct slot
    function automatic slot_kind_e slot_kind(input int i);
        if (i == WINDOW_SLOT) return SK_WINDOW;
        if (i == LOCKED_SLOT) return SK_LOCKED;
        if (i == CTRL_SLOT)   return SK_CTRL;
        return SK_PLAIN;
    endfunction

    // Role of an indirect entry
    function automatic entry_kind_e entry_kind(input int i);
        if (i == RO_ENTRY || i == CHIP_ENTRY) return EK_RO;
        if (i == VER_ENTRY)                   return EK_VER;
        return EK_PLAIN;
    endfunction

    // Power-up value of an indirect entry
    function automatic logic [7:0] entry_reset(input int i);
        if (i == VER_ENTRY)  return CODEC_VER;
        if (i == CHIP_ENTRY) return CHIP_VER;
        return 8'h00;
    endfunction

endpackage

// File: rtl/cdc_access_decode.sv
// Access decoder: turns the byte address and write strobe into a slot
// number, a one-hot direct write vector, a window write strobe and the
// soft-reset request. Assumes the address is in bytes with 4-byte slots.
module cdc_access_decode #(
    parameter int NUM_SLOTS = 16,
    parameter int DATA_W    = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ADDR_W   = SLOT_W + 2
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    input  logic                 wdata_lsb,
    output logic [SLOT_W-1:0]    slot,
    output logic [NUM_SLOTS-1:0] slot_wr,
    output logic                 win_wr,
    output logic                 soft_rst
);
    import cdc_regs_pkg::*;

    logic [1:0] lane_unused;

    // Byte lane bits carry no meaning for word-wide slots
    assign lane_unused = addr[1:0];
    assign slot        = addr[ADDR_W-1:2];

    // One write strobe per direct slot
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_wr
        assign slot_wr[i] = we && (slot == SLOT_W'(i));
    end

    // Window write and soft-reset request
    always_comb begin
        win_wr   = slot_wr[WINDOW_SLOT];
        soft_rst = slot_wr[CTRL_SLOT] && wdata_lsb;
    end

endmodule

// File: rtl/cdc_direct_bank.sv
// Direct slot bank: one 32-bit register per storing slot. The window and
// locked slots keep no storage and read as zero here. The control slot
// keeps the low bits of its write data, and its own write wins over the
// soft reset that same write raises. Assumes at most one slot is written
// per cycle.
module cdc_direct_bank #(
    parameter int NUM_SLOTS = 16,
    parameter int DATA_W    = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              soft_rst,
    input  logic [NUM_SLOTS-1:0]              slot_wr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]  dir_q
);
    import cdc_regs_pkg::*;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        if (slot_kind(i) == SK_CTRL) begin : g_ctrl
            logic [DATA_W-1:0] q;
            // Control slot: masked write has priority over the clear
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (slot_wr[i])
                    q <= {{(DATA_W-CTRL_KEEP_W){1'b0}}, wdata[CTRL_KEEP_W-1:0]};
                else if (soft_rst)
                    q <= '0;
            end
            assign dir_q[i] = q;
        end else if (slot_kind(i) == SK_PLAIN) begin : g_plain
            logic [DATA_W-1:0] q;
            // Plain slot: full-width store, cleared by either reset
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst)
                    q <= '0;
                else if (slot_wr[i])
                    q <= wdata;
            end
            assign dir_q[i] = q;
        end else begin : g_none
            // Window and locked slots hold nothing of their own
            assign dir_q[i] = '0;
        end
    end

endmodule

// File: rtl/cdc_indirect_bank.sv
// Indirect entry bank: 8-bit entries reached through the window slot.
// Read-only entries are constants equal to their power-up value. The
// version entry keeps one writable bit and fixed version bits. Assumes
// the index is already bounded to the entry count.
module cdc_indirect_bank #(
    parameter int NUM_IND = 32,
    parameter int IND_W   = 8,
    localparam int IDX_W  = $clog2(NUM_IND)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           soft_rst,
    input  logic                           win_wr,
    input  logic [IDX_W-1:0]               idx,
    input  logic [IND_W-1:0]               wdata,
    output logic [NUM_IND-1:0][IND_W-1:0]  ind_q
);
    import cdc_regs_pkg::*;

    for (genvar i = 0; i < NUM_IND; i++) begin : g_ent
        localparam logic [IND_W-1:0] RST_V = IND_W'(entry_reset(i));
        logic hit;
        assign hit = win_wr && (idx == IDX_W'(i));

        if (entry_kind(i) == EK_RO) begin : g_ro
            logic hit_unused;
            // Read-only entry: window writes are dropped
            assign hit_unused = hit;
            assign ind_q[i]   = RST_V;
        end else if (entry_kind(i) == EK_VER) begin : g_ver
            logic [IND_W-1:0] q;
            // Version entry: keep one bit, force the version code
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst)
                    q <= RST_V;
                else if (hit)
                    q <= (wdata & IND_W'(VER_KEEP)) | IND_W'(CODEC_VER);
            end
            assign ind_q[i] = q;
        end else begin : g_plain
            logic [IND_W-1:0] q;
            // Ordinary entry: store the low data byte
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst)
                    q <= RST_V;
                else if (hit)
                    q <= wdata;
            end
            assign ind_q[i] = q;
        end
    end

endmodule

// File: rtl/cdc_read_mux.sv
// Read path: returns the addressed direct slot, or for the window slot
// the selected indirect entry, zero-extended. The write-only entry reads
// as zero. Purely combinational.
module cdc_read_mux #(
    parameter int NUM_SLOTS = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_IND   = 32,
    parameter int IND_W     = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int IDX_W    = $clog2(NUM_IND)
) (
    input  logic [SLOT_W-1:0]                slot,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0] dir_q,
    input  logic [NUM_IND-1:0][IND_W-1:0]    ind_q,
    output logic [DATA_W-1:0]                rdata
);
    import cdc_regs_pkg::*;

    logic [IND_W-1:0] win_val;

    // Window value with the write-only entry hidden
    always_comb begin
        if (idx == IDX_W'(WO_ENTRY))
            win_val = '0;
        else
            win_val = ind_q[idx];
    end

    // Final read selection
    always_comb begin
        if (slot == SLOT_W'(WINDOW_SLOT))
            rdata = {{(DATA_W-IND_W){1'b0}}, win_val};
        else
            rdata = dir_q[slot];
    end

endmodule

// File: rtl/codec_regfile.sv
// Top of the indexed codec register file. Wires the decoder, both
// register banks and the read path. The window index comes from the low
// bits of the index slot. The interrupt output is tied low. Assumes a
// single host issuing at most one access per cycle.
module codec_regfile #(
    parameter int NUM_SLOTS = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_IND   = 32,
    parameter int IND_W     = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ADDR_W   = SLOT_W + 2,
    localparam int IDX_W    = $clog2(NUM_IND)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    import cdc_regs_pkg::*;

    logic [SLOT_W-1:0]                slot;
    logic [NUM_SLOTS-1:0]             slot_wr;
    logic                             win_wr;
    logic                             soft_rst;
    logic [IDX_W-1:0]                 win_idx;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] dir_q;
    logic [NUM_IND-1:0][IND_W-1:0]    ind_q;

    cdc_access_decode #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) dec_i (
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata_lsb (bus_wdata[0]),
        .slot      (slot),
        .slot_wr   (slot_wr),
        .win_wr    (win_wr),
        .soft_rst  (soft_rst)
    );

    cdc_direct_bank #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) dir_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .slot_wr  (slot_wr),
        .wdata    (bus_wdata),
        .dir_q    (dir_q)
    );

    // Window index taken from the index slot
    assign win_idx = dir_q[INDEX_SLOT][IDX_W-1:0];

    cdc_indirect_bank #(.NUM_IND(NUM_IND), .IND_W(IND_W)) ind_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .win_wr   (win_wr),
        .idx      (win_idx),
        .wdata    (bus_wdata[IND_W-1:0]),
        .ind_q    (ind_q)
    );

    cdc_read_mux #(
        .NUM_SLOTS (NUM_SLOTS),
        .DATA_W    (DATA_W),
        .NUM_IND   (NUM_IND),
        .IND_W     (IND_W)
    ) rd_i (
        .slot  (slot),
        .idx   (win_idx),
        .dir_q (dir_q),
        .ind_q (ind_q),
        .rdata (bus_rdata)
    );

    // No interrupt source lives in this block
    assign irq_out = 1'b0;

endmodule

// File: rtl/codec_regfile_chk.sv
// Checker for codec_regfile: port-level and state-level properties of
// the window, the fixed entries and the soft reset. Bound to the top.
module codec_regfile_chk #(
    parameter int NUM_SLOTS = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_IND   = 32,
    parameter int IND_W     = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int IDX_W    = $clog2(NUM_IND)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SLOT_W-1:0] slot,
    input logic              we,
    input logic [IDX_W-1:0]  wr_low,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic [IDX_W-1:0]  win_idx,
    input logic [IND_W-1:0]  ver_q,
    input logic [IND_W-1:0]  chip_q
);
    import cdc_regs_pkg::*;

    a_r11_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        irq == 1'b0);

    a_r3_window_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        slot == SLOT_W'(WINDOW_SLOT) |-> rdata[DATA_W-1:IND_W] == '0);

    a_r4_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_W'(WINDOW_SLOT) && win_idx == IDX_W'(WO_ENTRY)) |-> rdata == '0);

    a_r8_locked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        slot == SLOT_W'(LOCKED_SLOT) |-> rdata == '0);

    a_r6_chip_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        chip_q == IND_W'(CHIP_VER));

    a_r7_ver_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (ver_q & ~IND_W'(VER_KEEP)) == IND_W'(CODEC_VER));

    a_r3_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && slot == SLOT_W'(INDEX_SLOT)) |=> win_idx == $past(wr_low));

    a_r5_window_keeps_index: assert property (@(posedge clk) disable iff (!rst_n)
        (we && slot == SLOT_W'(WINDOW_SLOT)) |=> $stable(win_idx));

    a_r9_soft_clears_index: assert property (@(posedge clk) disable iff (!rst_n)
        (we && slot == SLOT_W'(CTRL_SLOT) && wr_low[0]) |=> win_idx == '0);

endmodule

bind codec_regfile codec_regfile_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .NUM_IND   (NUM_IND),
    .IND_W     (IND_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot    (slot),
    .we      (bus_we),
    .wr_low  (bus_wdata[IDX_W-1:0]),
    .rdata   (bus_rdata),
    .irq     (irq_out),
    .win_idx (win_idx),
    .ver_q   (ind_q[cdc_regs_pkg::VER_ENTRY]),
    .chip_q  (ind_q[cdc_regs_pkg::CHIP_ENTRY])
);

// File: tb/codec_regfile_tb_top.sv
// Bench: directed cases per requirement plus a random stream compared
// every cycle against a behavioural model.
module codec_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    // Behavioural model state
    logic [31:0] m_dir [16];
    logic [7:0]  m_ind [32];

    always #10 clk = ~clk;

    codec_regfile dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void m_reset();
        for (int i = 0; i < 16; i++) m_dir[i] = '0;
        for (int i = 0; i < 32; i++) m_ind[i] = '0;
        m_ind[12] = 8'h8A;
        m_ind[25] = 8'hA0;
    endfunction

    function automatic logic [31:0] m_read(input int slot);
        int idx;
        if (slot != 1) return m_dir[slot];
        idx = int'(m_dir[0][4:0]);
        if (idx == 3) return '0;
        return {24'h0, m_ind[idx]};
    endfunction

    function automatic void m_write(input int slot, input logic [31:0] d);
        int idx;
        idx = int'(m_dir[0][4:0]);
        case (slot)
            1: begin
                if (idx == 12)                 m_ind[idx] = (d[7:0] & 8'h40) | 8'h8A;
                else if (idx != 11 && idx != 25) m_ind[idx] = d[7:0];
            end
            2: ;
            4: begin
                if (d[0]) m_reset();
                m_dir[4] = d & 32'h7F;
            end
            default: m_dir[slot] = d;
        endcase
    endfunction

    // One bus cycle: drive, compare with model (and a literal if given), commit
    task automatic step(input int slot, input bit we, input logic [31:0] d,
                        input string tag, input bit has_exp, input logic [31:0] exp);
        @(negedge clk);
        bus_addr  = {4'(slot), 2'(slot)};
        bus_we    = we;
        bus_wdata = d;
        #5;
        check({tag, " model"}, bus_rdata, m_read(slot));
        if (has_exp) check(tag, bus_rdata, exp);
        check("R11 irq", {31'h0, irq_out}, 32'h0);
        @(posedge clk);
        if (we) m_write(slot, d);
    endtask

    task automatic wr(input int slot, input logic [31:0] d);
        step(slot, 1'b1, d, "R12 write", 1'b0, '0);
    endtask

    task automatic rd(input int slot, input logic [31:0] exp, input string tag);
        step(slot, 1'b0, '0, tag, 1'b1, exp);
    endtask

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: power-up state
        for (int s = 0; s < 16; s++) rd(s, 32'h0, "R1 slot");
        wr(0, 32'd12);
        rd(1, 32'h8A, "R1 entry12");
        wr(0, 32'd25);
        rd(1, 32'hA0, "R1 entry25");

        // R2: full-width direct slots
        wr(7, 32'hDEADBEEF);
        rd(7, 32'hDEADBEEF, "R2 slot7");
        wr(15, 32'h80000001);
        rd(15, 32'h80000001, "R2 slot15");

        // R3 / R5: index from low bits, window write
        wr(0, 32'hFFFFFFE5);
        rd(0, 32'hFFFFFFE5, "R2 slot0");
        wr(1, 32'hABCDEF3C);
        rd(1, 32'h0000003C, "R3 entry5");
        rd(0, 32'hFFFFFFE5, "R5 index kept");
        wr(0, 32'd6);
        rd(1, 32'h0, "R5 neighbour untouched");

        // R4: write-only entry
        wr(0, 32'd3);
        wr(1, 32'h77);
        rd(1, 32'h0, "R4 entry3");

        // R6: read-only entries
        wr(0, 32'd11);
        wr(1, 32'h55);
        rd(1, 32'h0, "R6 entry11");
        wr(0, 32'd25);
        wr(1, 32'h12);
        rd(1, 32'hA0, "R6 entry25");

        // R7: version entry masking
        wr(0, 32'd12);
        wr(1, 32'hFF);
        rd(1, 32'hCA, "R7 keep bit6");
        wr(1, 32'h00);
        rd(1, 32'h8A, "R7 clear bit6");

        // R8: locked slot
        wr(2, 32'h1234);
        rd(2, 32'h0, "R8 slot2");

        // R10: control slot without reset
        wr(0, 32'd5);
        wr(4, 32'hFFFFFFFE);
        rd(4, 32'h7E, "R10 masked");
        rd(1, 32'h3C, "R10 no reset");

        // R9: soft reset keeps the control write
        wr(4, 32'h000000FF);
        rd(4, 32'h7F, "R9 ctrl kept");
        rd(7, 32'h0, "R9 slot7 cleared");
        rd(0, 32'h0, "R9 index cleared");
        wr(0, 32'd5);
        rd(1, 32'h0, "R9 entry5 cleared");
        wr(0, 32'd12);
        rd(1, 32'h8A, "R9 entry12 version");

        // R12: random stream against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            int s;
            logic [31:0] d;
            s = int'($urandom_range(0, 15));
            d = $urandom;
            if (s == 4 && ($urandom_range(0, 7) != 0)) d[0] = 1'b0;
            step(s, bit'($urandom_range(0, 1)), d, "R12 random", 1'b0, '0);
        end

        @(negedge clk);
        bus_we = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule